// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This controller decides when a processor may run. It watches three conditions: a supply-good flag that an external voltage comparator has already synchronized, an active-low push-button, and a strobe that the running software must keep toggling. Whenever a condition calls for reset, the controller drives an active-low reset and its active-high complement. After the condition clears, it keeps the reset asserted for a fixed recovery interval.

The supply and button conditions are levels. Reset stays asserted for as long as either one is present, and the recovery interval runs only after both have cleared. The watchdog is a one-shot condition. When the strobe shows no transition for the timeout interval, a single recovery pulse is issued. The watchdog count is held clear while reset is asserted and while the watchdog is disabled. Both time constants are parameters counted in clock cycles, so the nominal 1.6 s timeout and 200 ms recovery map onto whatever clock the chip provides.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `arst_n` is low, `rst_n_o` is 0. After release, `rst_n_o` stays 0 for exactly REC_CYCLES rising edges and then goes to 1, provided no cause is present.
- R2: A 0 on `supply_ok` sampled at a rising edge makes `rst_n_o` 0 right after that edge. It stays 0 for as long as `supply_ok` remains 0.
- R3: After `supply_ok` returns to 1, `rst_n_o` goes to 1 on the REC_CYCLES-th rising edge at which `supply_ok` is sampled 1, and not earlier.
- R4: `btn_n` passes through a two-flop synchronizer. A 0 held on `btn_n` makes `rst_n_o` 0 after the third rising edge that samples it, and reset is held while the synchronized value stays 0.
- R5: After the synchronized `btn_n` returns to 1, reset is stretched for REC_CYCLES rising edges before release.
- R6: With `wd_en` at 1 and reset released, WD_CYCLES consecutive cycles without a transition of the synchronized strobe make the watchdog expire. Expiry asserts reset for exactly REC_CYCLES cycles.
- R7: A rising or a falling transition of the synchronized strobe restarts the watchdog count from zero.
- R8: The watchdog count is held at zero throughout reset. After any release, a full WD_CYCLES quiet cycles are needed before expiry.
- R9: While `wd_en` is 0, the watchdog never expires, whatever the strobe does.
- R10: `rst_o` is at all times the exact inverse of `rst_n_o`.
- R11: A cause that appears while the recovery interval is running reloads the full REC_CYCLES count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Asynchronous active-low controller reset |
| supply_ok | input | 1 | Synchronized supply-good flag, 1 = supply in tolerance |
| btn_n | input | 1 | Push-button reset, active low, asynchronous |
| wd_strobe | input | 1 | Watchdog strobe from software, asynchronous |
| wd_en | input | 1 | 1 enables the watchdog (quasi-static) |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |

## Verification
The bench goes after the release edge of each recovery interval. A counter that is off by one releases the processor one cycle early or late after power-on, after the supply returns, after the button is let go, or after a watchdog pulse. It drives strobe patterns that toggle just inside the timeout and patterns that hold steady across it. A design that restarts the count on only one edge expires early, and one that keeps counting during reset fires as soon as reset releases. It also reasserts the supply fault in the middle of a recovery interval and holds the watchdog disabled with a frozen strobe. A missing reload then shows up as a short reset, and a leaky enable shows up as a spurious pulse.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // Individual reset causes as seen by the recovery stage.
  typedef struct packed {
    logic supply_bad;
    logic button;
    logic wd_expire;
  } cause_t;

  // Reset values of the synchronizer lanes: bit 0 button (idle high), bit 1 strobe.
  localparam logic [1:0] SYNC_IDLE = 2'b01;
  localparam int SYNC_LANES = 2;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        meta_q[i] <= IDLE[i];
        sync_q[i] <= IDLE[i];
      end else begin
        meta_q[i] <= din[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic strobe_s,
  input  logic enable,
  input  logic hold_clr,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          edge_seen, clear, cnt_en;

  // next-state logic
  always_comb begin
    edge_seen = strobe_s ^ prev_q;
    expire    = enable & ~hold_clr & ~edge_seen & (cnt_q == LAST);
    clear     = ~enable | hold_clr | edge_seen | expire;
    cnt_en    = clear | (cnt_q != LAST);
    cnt_d     = clear ? '0 : cnt_q + CW'(1);
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= strobe_s;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sup_recovery.sv
module sup_recovery #(
  parameter int RECOVERY = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic reload,
  output logic active
);
  localparam int CW = $clog2(RECOVERY + 1);
  localparam logic [CW-1:0] FULL = CW'(RECOVERY);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // next-state logic
  always_comb begin
    active = (cnt_q != '0);
    cnt_en = reload | active;
    cnt_d  = reload ? FULL : cnt_q - CW'(1);
  end

  // registers: controller reset loads a full recovery interval
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= FULL;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_pkg::*;
#(
  parameter int WD_CYCLES  = 16,
  parameter int REC_CYCLES = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok,
  input  logic btn_n,
  input  logic wd_strobe,
  input  logic wd_en,
  output logic rst_n_o,
  output logic rst_o
);
  logic [SYNC_LANES-1:0] raw, synced;
  cause_t                cause;
  logic                  in_reset;
  logic                  expire;

  assign raw = {wd_strobe, btn_n};

  sup_sync #(.WIDTH(SYNC_LANES), .IDLE(SYNC_IDLE)) sync_i (
    .clk    (clk),
    .arst_n (arst_n),
    .din    (raw),
    .dout   (synced)
  );

  sup_wdog #(.TIMEOUT(WD_CYCLES)) wdog_i (
    .clk      (clk),
    .arst_n   (arst_n),
    .strobe_s (synced[1]),
    .enable   (wd_en),
    .hold_clr (in_reset),
    .expire   (expire)
  );

  always_comb begin
    cause.supply_bad = ~supply_ok;
    cause.button     = ~synced[0];
    cause.wd_expire  = expire;
  end

  sup_recovery #(.RECOVERY(REC_CYCLES)) rec_i (
    .clk    (clk),
    .arst_n (arst_n),
    .reload (|cause),
    .active (in_reset)
  );

  assign rst_n_o = ~in_reset;
  assign rst_o   = in_reset;
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk (
  input logic clk,
  input logic arst_n,
  input logic supply_ok,
  input logic btn_n,
  input logic wd_strobe,
  input logic wd_en,
  input logic rst_n_o,
  input logic rst_o
);
  // R10
  complement_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_o == !rst_n_o);

  // R2
  supply_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |=> !rst_n_o);

  // R3
  release_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> $past(supply_ok));

  // R9
  fall_has_cause_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_n_o) |-> (!$past(supply_ok) || !$past(btn_n, 3) || $past(wd_en)));
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk chk_i (.*);

// File: tb/sup_reset_ctrl_tb.sv
module sup_reset_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD  = 12;
  localparam int REC = 8;

  logic clk = 1'b0;
  logic arst_n, supply_ok, btn_n, wd_strobe, wd_en;
  logic rst_n_o, rst_o;

  int    errors = 0;
  int    checks = 0;
  string phase  = "R1";

  sup_reset_ctrl #(.WD_CYCLES(WD), .REC_CYCLES(REC)) dut_i (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .btn_n(btn_n),
    .wd_strobe(wd_strobe), .wd_en(wd_en), .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements
  logic mb1, mb2, mw1, mw2, mwp;
  int   mwd, mrec;

  function automatic int rec_next(bit hold, bit expd, int cur);
    if (hold || expd) return REC;
    return (cur > 0) ? cur - 1 : 0;
  endfunction

  function automatic bit wd_fires(bit en, bit active, bit edge_s, int cnt);
    return en && !active && !edge_s && (cnt == WD - 1);
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mb1 <= 1'b1; mb2 <= 1'b1; mw1 <= 1'b0; mw2 <= 1'b0; mwp <= 1'b0;
      mwd <= 0; mrec <= REC;
    end else begin : upd
      bit hold, edge_s, act, fire;
      hold   = !supply_ok || !mb2;
      edge_s = (mw2 != mwp);
      act    = (mrec != 0);
      fire   = wd_fires(wd_en, act, edge_s, mwd);
      mrec <= rec_next(hold, fire, mrec);
      mwd  <= (!wd_en || act || edge_s || fire) ? 0 : mwd + 1;
      mb1 <= btn_n; mb2 <= mb1;
      mw1 <= wd_strobe; mw2 <= mw1; mwp <= mw2;
    end
  end

  task automatic check_outputs();
    bit exp_n;
    exp_n = (mrec == 0);
    checks++;
    if (rst_n_o !== exp_n) begin
      errors++;
      $display("FAIL %s: rst_n_o=%0b expected %0b at %0t", phase, rst_n_o, exp_n, $time);
    end
    checks++;
    if (rst_o !== ~rst_n_o) begin // R10
      errors++;
      $display("FAIL R10: rst_o=%0b expected %0b at %0t", rst_o, ~rst_n_o, $time);
    end
  endtask

  // One cycle: compare away from the edge, then drive the next inputs
  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_outputs();
    end
  endtask

  task automatic toggle_run(int n, int period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_outputs();
      if ((i % period) == 0) wd_strobe = ~wd_strobe;
    end
  endtask

  initial begin
    arst_n = 1'b0; supply_ok = 1'b1; btn_n = 1'b1; wd_strobe = 1'b0; wd_en = 1'b1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checks++;
    if (rst_n_o !== 1'b0) begin // R1 reset state
      errors++;
      $display("FAIL R1: rst_n_o=%0b expected 0 during controller reset", rst_n_o);
    end
    arst_n = 1'b1;
    phase = "R1";  toggle_run(20, 2);
    phase = "R2";  supply_ok = 1'b0; toggle_run(6, 2);
    phase = "R3";  supply_ok = 1'b1; toggle_run(16, 2);
    phase = "R4";  btn_n = 1'b0; toggle_run(6, 2);
    phase = "R5";  btn_n = 1'b1; toggle_run(18, 2);
    phase = "R6";  step(45);
    phase = "R7";  toggle_run(60, WD - 1);
    phase = "R8";  supply_ok = 1'b0; step(30);
    supply_ok = 1'b1; step(REC + WD + 4);
    phase = "R9";  toggle_run(10, 2); wd_en = 1'b0; step(60);
    wd_en = 1'b1;  toggle_run(10, 2);
    phase = "R11"; supply_ok = 1'b0; step(2); supply_ok = 1'b1; step(4);
    supply_ok = 1'b0; step(1); supply_ok = 1'b1; toggle_run(14, 2);
    btn_n = 1'b0; step(1); btn_n = 1'b1; toggle_run(16, 3);
    phase = "mixed R2 R4 R6";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      check_outputs();
      supply_ok = ($urandom_range(0, 99) > 3);
      btn_n     = ($urandom_range(0, 99) > 3);
      if ($urandom_range(0, 99) < 12) wd_strobe = ~wd_strobe;
      if ($urandom_range(0, 99) < 2)  wd_en = ~wd_en;
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL guard: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule